// File: doc/BRIEF.md
# Result Assignment And Method Send Unit

This unit sits after the ALU of a small command-processing engine. For each value-producing instruction it receives the 32-bit result, the assignment mode and the destination register index. The upstream decoder takes the mode from instruction bits 6:4 and the destination from bits 10:8. According to the mode, the unit does some or all of the following: it writes a register, it pops a word from the parameter FIFO, it reloads the method address and its step, and it emits an (address, data) pair on the send output.

The unit holds a 12-bit method address and a 6-bit step. Loading them from a value takes the address from bits 11:0 of that value and the step from bits 17:12. Each completed send advances the address by the step, wrapping modulo 4096. One mode sets the address and sends in the same instruction, and the send then goes to the address it has just loaded.

An instruction stays presented on `in_valid` until `in_ready`. It stalls while a parameter it needs is missing or while its send is not accepted. It commits everything in the single cycle in which it completes: the pop, the send, the register write and the address update.

Top module: `res_assign_send`

## Requirements
- R1: Mode encoding on `in_mode`: 0 fetch-ignore, 1 move, 2 move-set-address, 3 fetch-send, 4 move-send, 5 fetch-set-address, 6 move-set-address-fetch-send, 7 move-set-address-send-high. In move (1) the unit writes the result to register `in_dst` and neither pops nor sends.
- R2: An instruction whose destination index is 0 completes without asserting `rf_we`.
- R3: Move-set-address (2) writes the result and loads the method address from result bits 11:0 and the step from result bits 17:12.
- R4: Each completed send advances the method address by the step, modulo 4096.
- R5: Fetch-ignore (0) discards the result, pops one parameter and writes that parameter to the destination.
- R6: Fetch-send (3) pops a parameter, writes it to the destination and sends the result to the current method address.
- R7: Fetch-set-address (5) pops a parameter, writes it to the destination, and loads the address and step from the result without sending.
- R8: Mode 6 writes the result and loads the address from it. It then sends the popped parameter to that newly loaded address.
- R9: Mode 7 writes the result and loads the address from it. It then sends result bits 17:12, zero-extended, to that newly loaded address.
- R10: Move-send (4) writes the result and sends it to the current address.
- R11: An instruction waiting for a parameter, or for `snd_ready`, keeps `in_ready`, `rf_we` and `prm_ready` low and leaves the address unchanged. `snd_valid` waits for the parameter as well.
- R12: After reset the method address and step are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction result is presented |
| in_mode | input | 3 | Assignment mode |
| in_dst | input | 3 | Destination register index |
| in_result | input | 32 | ALU result |
| in_ready | output | 1 | Instruction completes this cycle |
| prm_valid | input | 1 | Parameter FIFO holds a word |
| prm_data | input | 32 | Parameter FIFO head word |
| prm_ready | output | 1 | Pop the parameter FIFO |
| rf_we | output | 1 | Register write enable |
| rf_idx | output | 3 | Register write index |
| rf_data | output | 32 | Register write data |
| snd_valid | output | 1 | Send pair offered |
| snd_ready | input | 1 | Send pair accepted |
| snd_addr | output | 12 | Send method address |
| snd_data | output | 32 | Send data |

## Verification
The bench sets a known address and step, then follows them through chains of sends. A unit that skipped the step, used the step from before a reload, or failed to wrap past 4095 would send to the wrong address. Modes 6 and 7 must send to the address loaded in the same instruction; a unit that used the old address there would be caught. Stalls are tested with the FIFO empty and with the sink busy. A unit that popped or wrote while waiting, or that moved the address during a stall, would show a spurious `prm_ready` or `rf_we`, or a shifted address on the following send. Writes to register 0 and the routing of parameter versus result into the register file are checked in each fetch mode.

// File: rtl/res_assign_send.sv
module res_assign_send #(
  parameter int DW = 32,
  parameter int AW = 12,
  parameter int IW = 6,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    in_mode,
  input  logic [RW-1:0] in_dst,
  input  logic [DW-1:0] in_result,
  output logic          in_ready,
  input  logic          prm_valid,
  input  logic [DW-1:0] prm_data,
  output logic          prm_ready,
  output logic          rf_we,
  output logic [RW-1:0] rf_idx,
  output logic [DW-1:0] rf_data,
  output logic          snd_valid,
  input  logic          snd_ready,
  output logic [AW-1:0] snd_addr,
  output logic [DW-1:0] snd_data
);
  localparam int HI = AW + IW;

  logic [AW-1:0] maddr_q, cur_addr;
  logic [IW-1:0] incr_q, cur_incr;
  logic fetch, send, setad, wr_prm;
  logic [1:0] dsel;

  always_comb begin
    fetch = 1'b0; send = 1'b0; setad = 1'b0; wr_prm = 1'b0; dsel = 2'd0;
    case (in_mode)
      3'd0: begin fetch = 1'b1; wr_prm = 1'b1; end
      3'd1: ;
      3'd2: setad = 1'b1;
      3'd3: begin fetch = 1'b1; wr_prm = 1'b1; send = 1'b1; end
      3'd4: send = 1'b1;
      3'd5: begin fetch = 1'b1; wr_prm = 1'b1; setad = 1'b1; end
      3'd6: begin fetch = 1'b1; send = 1'b1; setad = 1'b1; dsel = 2'd1; end
      default: begin send = 1'b1; setad = 1'b1; dsel = 2'd2; end
    endcase
  end

  wire prm_ok = !fetch || prm_valid;
  wire snd_ok = !send || snd_ready;

  assign in_ready  = in_valid && prm_ok && snd_ok;
  assign prm_ready = in_ready && fetch;
  assign snd_valid = in_valid && send && prm_ok;

  assign cur_addr = setad ? in_result[AW-1:0] : maddr_q;
  assign cur_incr = setad ? in_result[HI-1:AW] : incr_q;

  assign rf_we   = in_ready && (in_dst != '0);
  assign rf_idx  = in_dst;
  assign rf_data = wr_prm ? prm_data : in_result;

  assign snd_addr = cur_addr;
  assign snd_data = (dsel == 2'd1) ? prm_data :
                    (dsel == 2'd2) ? {{(DW-IW){1'b0}}, in_result[HI-1:AW]} :
                    in_result;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maddr_q <= '0;
      incr_q  <= '0;
    end else if (in_ready) begin
      maddr_q <= send ? cur_addr + {{(AW-IW){1'b0}}, cur_incr} : cur_addr;
      incr_q  <= cur_incr;
    end
  end
endmodule

// File: rtl/res_assign_send_chk.sv
module res_assign_send_chk #(
  parameter int AW = 12,
  parameter int IW = 6,
  parameter int RW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [2:0]    in_mode,
  input logic          in_ready,
  input logic          prm_valid,
  input logic          prm_ready,
  input logic          rf_we,
  input logic [RW-1:0] rf_idx,
  input logic          snd_valid,
  input logic          snd_ready,
  input logic [AW-1:0] snd_addr,
  input logic [AW-1:0] maddr_q,
  input logic [IW-1:0] incr_q
);
  // R11
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prm_ready |-> prm_valid && in_ready);

  // R2
  no_reg0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rf_idx != '0);

  // R11
  write_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> in_ready);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_valid && snd_ready) |=> maddr_q == $past(snd_addr) + {{(AW-IW){1'b0}}, incr_q});

  // R1
  move_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 3'd1) |-> !snd_valid && !prm_ready);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(maddr_q) && $stable(incr_q));
endmodule

bind res_assign_send res_assign_send_chk #(.AW(AW), .IW(IW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
  .in_ready(in_ready), .prm_valid(prm_valid), .prm_ready(prm_ready),
  .rf_we(rf_we), .rf_idx(rf_idx), .snd_valid(snd_valid), .snd_ready(snd_ready),
  .snd_addr(snd_addr), .maddr_q(maddr_q), .incr_q(incr_q)
);

// File: tb/tb_res_assign_send.sv
module tb_res_assign_send;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, prm_valid = 1'b0, snd_ready = 1'b0;
  logic [2:0] in_mode = '0, in_dst = '0;
  logic [31:0] in_result = '0, prm_data = '0;
  logic in_ready, prm_ready, rf_we, snd_valid;
  logic [2:0] rf_idx;
  logic [31:0] rf_data, snd_data;
  logic [11:0] snd_addr;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  res_assign_send dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic present(logic [2:0] m, logic [2:0] d, logic [31:0] r,
                         logic pv, logic [31:0] pd, logic sr);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_dst = d; in_result = r;
    prm_valid = pv; prm_data = pd; snd_ready = sr;
    #1;
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; prm_valid = 1'b0; snd_ready = 1'b0;
  endtask

  task automatic send_at(string req, logic [11:0] exp_addr, logic [31:0] val);
    present(3'd4, 3'd7, val, 1'b0, '0, 1'b1);
    chk(req, {20'd0, snd_addr}, {20'd0, exp_addr});
    chk(req, snd_data, val);
    idle();
  endtask

  task automatic t_reset();
    chk("R12", {31'd0, snd_valid | rf_we | prm_ready | in_ready}, 32'd0);
    send_at("R12", 12'h000, 32'h11);
    send_at("R12", 12'h000, 32'h12);
  endtask

  task automatic t_move();
    present(3'd1, 3'd3, 32'hDEAD_BEEF, 1'b1, 32'h5, 1'b1);
    chk("R1", {29'd0, in_ready, rf_we, snd_valid}, 32'b110);
    chk("R1", {29'd0, rf_idx}, 32'd3);
    chk("R1", rf_data, 32'hDEAD_BEEF);
    chk("R1", {31'd0, prm_ready}, 32'd0);
    idle();
  endtask

  task automatic t_reg0();
    present(3'd0, 3'd0, 32'h1, 1'b1, 32'h77, 1'b0);
    chk("R2", {30'd0, in_ready, rf_we}, 32'b10);
    chk("R2", {31'd0, prm_ready}, 32'd1);
    idle();
  endtask

  task automatic t_set_and_step();
    present(3'd2, 3'd5, 32'h0000_4010, 1'b0, '0, 1'b0);
    chk("R3", {30'd0, in_ready, snd_valid}, 32'b10);
    chk("R3", rf_data, 32'h0000_4010);
    idle();
    send_at("R3", 12'h010, 32'hA0);
    send_at("R4", 12'h014, 32'hA1);
    send_at("R4", 12'h018, 32'hA2);
  endtask

  task automatic t_wrap();
    present(3'd2, 3'd1, 32'h0000_3FFE, 1'b0, '0, 1'b0);
    idle();
    send_at("R4", 12'hFFE, 32'hB0);
    send_at("R4", 12'h001, 32'hB1);
  endtask

  task automatic t_fetch_ignore();
    present(3'd0, 3'd2, 32'h1234, 1'b0, '0, 1'b0);
    chk("R11", {29'd0, in_ready, rf_we, prm_ready}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    prm_valid = 1'b1; prm_data = 32'hCAFE_0001;
    #1;
    chk("R5", {29'd0, in_ready, rf_we, prm_ready}, 32'b111);
    chk("R5", rf_data, 32'hCAFE_0001);
    chk("R5", {31'd0, snd_valid}, 32'd0);
    idle();
  endtask

  task automatic t_fetch_send();
    present(3'd2, 3'd1, 32'h0000_1040, 1'b0, '0, 1'b0);
    idle();
    present(3'd3, 3'd4, 32'h5555, 1'b1, 32'h6666, 1'b0);
    chk("R11", {28'd0, in_ready, rf_we, prm_ready, snd_valid}, 32'b0001);
    @(posedge clk);
    @(negedge clk);
    snd_ready = 1'b1;
    #1;
    chk("R6", {28'd0, in_ready, rf_we, prm_ready, snd_valid}, 32'b1111);
    chk("R6", rf_data, 32'h6666);
    chk("R6", snd_data, 32'h5555);
    chk("R11", {20'd0, snd_addr}, 32'h040);
    idle();
    send_at("R6", 12'h041, 32'hC0);
  endtask

  task automatic t_fetch_set();
    present(3'd5, 3'd6, 32'h0000_8300, 1'b1, 32'h9999, 1'b1);
    chk("R7", {28'd0, in_ready, rf_we, prm_ready, snd_valid}, 32'b1110);
    chk("R7", rf_data, 32'h9999);
    idle();
    send_at("R7", 12'h300, 32'hD0);
    send_at("R7", 12'h308, 32'hD1);
  endtask

  task automatic t_set_fetch_send();
    present(3'd6, 3'd3, 32'h0000_2100, 1'b0, '0, 1'b1);
    chk("R11", {29'd0, in_ready, snd_valid, prm_ready}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    prm_valid = 1'b1; prm_data = 32'h0BAD_F00D;
    #1;
    chk("R8", {28'd0, in_ready, rf_we, prm_ready, snd_valid}, 32'b1111);
    chk("R8", rf_data, 32'h0000_2100);
    chk("R8", {20'd0, snd_addr}, 32'h100);
    chk("R8", snd_data, 32'h0BAD_F00D);
    idle();
    send_at("R8", 12'h102, 32'hE0);
  endtask

  task automatic t_send_high();
    present(3'd7, 3'd2, 32'hFFF5_5200, 1'b0, '0, 1'b1);
    chk("R9", {28'd0, in_ready, rf_we, prm_ready, snd_valid}, 32'b1101);
    chk("R9", rf_data, 32'hFFF5_5200);
    chk("R9", {20'd0, snd_addr}, 32'h200);
    chk("R9", snd_data, 32'h0000_0015);
    idle();
    send_at("R9", 12'h215, 32'hF0);
  endtask

  task automatic t_move_send();
    present(3'd2, 3'd1, 32'h0000_1000, 1'b0, '0, 1'b0);
    idle();
    present(3'd4, 3'd5, 32'h4242, 1'b1, 32'h1, 1'b0);
    chk("R11", {29'd0, in_ready, rf_we, snd_valid}, 32'b001);
    @(posedge clk);
    @(negedge clk);
    snd_ready = 1'b1;
    #1;
    chk("R10", {28'd0, in_ready, rf_we, prm_ready, snd_valid}, 32'b1101);
    chk("R10", rf_data, 32'h4242);
    chk("R10", snd_data, 32'h4242);
    chk("R10", {20'd0, snd_addr}, 32'h000);
    idle();
    send_at("R10", 12'h001, 32'h43);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_move();
        t_reg0();
        t_set_and_step();
        t_wrap();
        t_fetch_ignore();
        t_fetch_send();
        t_fetch_set();
        t_set_fetch_send();
        t_send_high();
        t_move_send();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule